// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked front end of a synchronous burst SRAM whose data pins are shared between reads and writes. On every rising clock edge it samples three chip selects, two competing address strobes (one driven by a processor, one by a memory controller), a global write, a byte-write enable and one write strobe per byte lane. From these it decides whether a new access begins, whether that access is a read or a write, and which byte lanes a write touches. When an access begins, it captures the address and the two-bit seed for the burst counter.

The block issues a one-cycle access request with per-lane write enables to the memory core. It also produces the enable for the shared data-bus drivers. That enable follows the asynchronous output-enable pin combinationally. It is forced off while a write is current, whatever the output-enable pin says. Burst advance and power-down belong to other blocks. The storage array sits outside this block.

Top module: `sbc_ctrl`

## Requirements
- R1: The chip counts as selected when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A controller-strobe access starts on a rising edge when the chip is selected, `ctl_as_n`=0 and `cpu_as_n`=1. It is a write when the write inputs encode one (R4, R5) and a read otherwise.
- R2: If `cpu_as_n`=0 on an edge, `ctl_as_n` has no effect on that edge.
- R3: On each edge that starts an access, `core_addr` takes `addr_in` and `burst_seed` takes `addr_in[1:0]`. On any other edge both keep their values.
- R4: With `all_wr_n`=0, a controller-strobe write enables every lane, whatever `bytes_wr_n` and `lane_wr_n` hold.
- R5: With `all_wr_n`=1 and `bytes_wr_n`=0, lane i is written exactly when `lane_wr_n[i]`=0. If `bytes_wr_n`=1, or if no lane strobe is low, the access is a read.
- R6: While the current access is a write, `bus_drive` is 0 even when `oe_n`=0.
- R7: While the current access is a read, `bus_drive` equals the inverse of `oe_n` at once, without waiting for a clock edge.
- R8: An edge on which either strobe is low but the chip is not selected deselects the device. No request is issued and `bus_drive` stays 0 until the next access starts.
- R9: A processor-strobe access on a selected chip starts as a read, even if the write inputs are active.
- R10: `core_req` is high for exactly the one cycle after a starting edge. `core_we` is nonzero only in such a cycle, and only for a write.
- R11: After reset `core_req`=0, `core_we`=0, `core_addr`=0, `burst_seed`=0 and `bus_drive`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| cpu_as_n | input | 1 | Processor address strobe, active low, has priority |
| ctl_as_n | input | 1 | Controller address strobe, active low |
| all_wr_n | input | 1 | Global write, active low, writes all lanes |
| bytes_wr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr_in | input | ADDR_W | Presented address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| core_req | output | 1 | One-cycle access request to the core |
| core_we | output | LANES | Per-lane write enables to the core |
| core_addr | output | ADDR_W | Captured address |
| burst_seed | output | 2 | Burst counter seed |
| bus_drive | output | 1 | Enable for the shared data-bus drivers |

## Verification
The bench drives both strobes low together with write inputs active. A design that inverted the priority or let the write inputs through on a processor start would then write the core and let go of the bus. It presents byte writes with single lanes, with no lanes and with the byte enable off. It also presents a global write with all lane strobes high, so that a misread lane mask shows up as corrupted bytes in the bench's memory array. While an access is held, it toggles `oe_n` between clock edges and across write phases. This exposes a registered output enable, or a bus driver that ignores writes. It also sends strobes to an unselected chip and runs idle edges, which catch a design that issues requests or moves the address when it should not.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  localparam int unsigned SEED_W = 2;

  // all three selects in their active state
  function automatic logic chip_on(input logic s0_n, input logic s1, input logic s2_n);
    return (!s0_n) && s1 && (!s2_n);
  endfunction
endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             cpu_as_n,
  input  logic             ctl_as_n,
  input  logic             all_wr_n,
  input  logic             bytes_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic             start_cpu,
  output logic             start_ctl,
  output logic             desel,
  output logic             start_any,
  output logic [LANES-1:0] wr_mask
);
  function automatic logic [LANES-1:0] lane_mask(input logic gw_n, input logic bwe_n,
                                                 input logic [LANES-1:0] bw_n);
    if (!gw_n)       return '1;
    else if (!bwe_n) return ~bw_n;
    else             return '0;
  endfunction

  logic chip_sel;
  logic any_strobe;
  logic [LANES-1:0] raw_mask;

  always_comb begin
    chip_sel   = chip_on(sel0_n, sel1, sel2_n);
    any_strobe = !cpu_as_n || !ctl_as_n;
    raw_mask   = lane_mask(all_wr_n, bytes_wr_n, lane_wr_n);
    start_cpu  = chip_sel && !cpu_as_n;
    start_ctl  = chip_sel && cpu_as_n && !ctl_as_n;
    desel      = !chip_sel && any_strobe;
    start_any  = start_cpu || start_ctl;
    wr_mask    = start_ctl ? raw_mask : '0;
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_cpu, start_ctl, desel}));

  // R9
  cpu_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_cpu |-> (wr_mask == '0));
endmodule

// File: rtl/sbc_capture.sv
module sbc_capture
  import sbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SEED_W-1:0] seed_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      seed_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      seed_q <= addr_in[SEED_W-1:0];
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(addr_q) && $stable(seed_q)));
endmodule

// File: rtl/sbc_phase.sv
module sbc_phase
  import sbc_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cpu,
  input  logic             start_ctl,
  input  logic             desel,
  input  logic [LANES-1:0] wr_mask,
  output phase_t           phase_q,
  output logic             req_q,
  output logic [LANES-1:0] we_q
);
  phase_t phase_d;
  logic   is_wr;

  always_comb begin
    is_wr   = start_ctl && (wr_mask != '0);
    phase_d = phase_q;
    if (start_cpu)      phase_d = PH_READ;
    else if (start_ctl) phase_d = is_wr ? PH_WRITE : PH_READ;
    else if (desel)     phase_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      req_q   <= 1'b0;
      we_q    <= '0;
    end else begin
      phase_q <= phase_d;
      req_q   <= start_cpu || start_ctl;
      we_q    <= is_wr ? wr_mask : '0;
    end
  end

  // R10
  we_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_q != '0) |-> (req_q && phase_q == PH_WRITE));

  // R8
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> (!req_q && phase_q == PH_IDLE));

  // R9
  cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_cpu |=> (phase_q == PH_READ && we_q == '0));
endmodule

// File: rtl/sbc_busgate.sv
module sbc_busgate
  import sbc_pkg::*;
(
  input  phase_t phase_q,
  input  logic   oe_n,
  output logic   bus_drive
);
  always_comb bus_drive = (phase_q == PH_READ) && !oe_n;
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              cpu_as_n,
  input  logic              ctl_as_n,
  input  logic              all_wr_n,
  input  logic              bytes_wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              oe_n,
  output logic              core_req,
  output logic [LANES-1:0]  core_we,
  output logic [ADDR_W-1:0] core_addr,
  output logic [1:0]        burst_seed,
  output logic              bus_drive
);
  logic             start_cpu, start_ctl, desel, start_any;
  logic [LANES-1:0] wr_mask;
  phase_t           phase_q;

  sbc_decode #(.LANES(LANES)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .cpu_as_n(cpu_as_n), .ctl_as_n(ctl_as_n),
    .all_wr_n(all_wr_n), .bytes_wr_n(bytes_wr_n), .lane_wr_n(lane_wr_n),
    .start_cpu(start_cpu), .start_ctl(start_ctl), .desel(desel),
    .start_any(start_any), .wr_mask(wr_mask)
  );

  sbc_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(start_any), .addr_in(addr_in),
    .addr_q(core_addr), .seed_q(burst_seed)
  );

  sbc_phase #(.LANES(LANES)) u_ph (
    .clk(clk), .rst_n(rst_n),
    .start_cpu(start_cpu), .start_ctl(start_ctl), .desel(desel),
    .wr_mask(wr_mask), .phase_q(phase_q), .req_q(core_req), .we_q(core_we)
  );

  sbc_busgate u_bus (
    .phase_q(phase_q), .oe_n(oe_n), .bus_drive(bus_drive)
  );

  // R6
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we != '0) |-> !bus_drive);

  // R10
  req_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_any |=> !core_req);

  // R1
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ctl && wr_mask != '0) |=> (core_req && core_we != '0));
endmodule

// File: tb/sim_sbc_ctrl.sv
module sim_sbc_ctrl;
  localparam int unsigned ADDR_W = 19;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DW     = LANES * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic cpu_as_n = 1'b1, ctl_as_n = 1'b1;
  logic all_wr_n = 1'b1, bytes_wr_n = 1'b1;
  logic [LANES-1:0] lane_wr_n = '1;
  logic [ADDR_W-1:0] addr_in = '0;
  logic oe_n = 1'b1;
  logic core_req, bus_drive;
  logic [LANES-1:0] core_we;
  logic [ADDR_W-1:0] core_addr;
  logic [1:0] burst_seed;

  always #4 clk = ~clk;

  sbc_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .cpu_as_n(cpu_as_n), .ctl_as_n(ctl_as_n), .all_wr_n(all_wr_n),
    .bytes_wr_n(bytes_wr_n), .lane_wr_n(lane_wr_n), .addr_in(addr_in),
    .oe_n(oe_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .burst_seed(burst_seed), .bus_drive(bus_drive)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model state: 0 idle, 1 read, 2 write
  int m_phase = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic m_req = 1'b0;
  logic [LANES-1:0] m_we = '0;
  logic [DW-1:0] dut_mem [16];
  logic [DW-1:0] exp_mem [16];
  logic [DW-1:0] wdata;

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [LANES-1:0] expect_lanes(input logic gw_n, input logic bwe_n,
                                                    input logic [LANES-1:0] bw_n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++)
      m[i] = (gw_n == 1'b0) | ((bwe_n == 1'b0) & (bw_n[i] == 1'b0));
    return m;
  endfunction

  // advance the model over one edge using the inputs now applied
  task automatic model_edge();
    bit sel = (sel0_n == 1'b0) && (sel1 == 1'b1) && (sel2_n == 1'b0);
    logic [LANES-1:0] lanes = expect_lanes(all_wr_n, bytes_wr_n, lane_wr_n);
    m_req = 1'b0;
    m_we  = '0;
    if (sel && cpu_as_n == 1'b0) begin
      m_req = 1'b1; m_phase = 1; m_addr = addr_in;
    end else if (sel && ctl_as_n == 1'b0) begin
      m_req = 1'b1; m_addr = addr_in; m_we = lanes;
      m_phase = (lanes != 0) ? 2 : 1;
    end else if (!sel && (cpu_as_n == 1'b0 || ctl_as_n == 1'b0)) begin
      m_phase = 0;
    end
  endtask

  // one clock: edge, settle, compare, exercise oe_n asynchronously
  task automatic step(input string tag);
    logic keep_oe;
    model_edge();
    @(posedge clk);
    #2;
    chk(tag, "core_req R10", core_req, m_req);
    chk(tag, "core_we R5", core_we, m_we);
    chk(tag, "core_addr R3", core_addr, m_addr);
    chk(tag, "burst_seed R3", burst_seed, m_addr[1:0]);
    chk(tag, "bus_drive R6", bus_drive, (m_phase == 1) && !oe_n);
    keep_oe = oe_n;
    oe_n = ~oe_n;
    #1;
    chk(tag, "bus_drive async R7", bus_drive, (m_phase == 1) && !oe_n);
    oe_n = keep_oe;
    #1;
    for (int i = 0; i < LANES; i++) begin
      if (core_we[i]) dut_mem[core_addr[3:0]][i*8 +: 8] = wdata[i*8 +: 8];
      if (m_we[i])    exp_mem[m_addr[3:0]][i*8 +: 8]    = wdata[i*8 +: 8];
    end
    wdata = $urandom;
  endtask

  task automatic set_sel(input bit on);
    sel0_n = !on; sel1 = on; sel2_n = !on;
  endtask

  task automatic set_cmd(input bit cpu, input bit ctl, input bit gw, input bit bwe,
                         input logic [LANES-1:0] bw, input logic [ADDR_W-1:0] a);
    cpu_as_n = !cpu; ctl_as_n = !ctl; all_wr_n = !gw; bytes_wr_n = !bwe;
    lane_wr_n = ~bw; addr_in = a;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5bc0_1234));
    for (int i = 0; i < 16; i++) begin dut_mem[i] = '0; exp_mem[i] = '0; end
    wdata = 32'hA1B2_C3D4;
    #20;
    // R11 reset state
    chk("R11", "core_req", core_req, 0);
    chk("R11", "core_we", core_we, 0);
    chk("R11", "core_addr", core_addr, 0);
    chk("R11", "burst_seed", burst_seed, 0);
    oe_n = 1'b0; #1;
    chk("R11", "bus_drive", bus_drive, 0);
    oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 global write with every lane strobe inactive
    set_sel(1); oe_n = 1'b0;
    set_cmd(0, 1, 1, 0, '0, 19'h00015);
    step("R4");
    chk("R4", "all lanes", core_we, 4'hF);
    chk("R6", "write with oe active", bus_drive, 0);
    // R5 single lane byte write
    set_cmd(0, 1, 0, 1, 4'b0100, 19'h00016);
    step("R5");
    chk("R5", "lane two only", core_we, 4'b0100);
    // R5 byte enable off -> read
    set_cmd(0, 1, 0, 0, 4'b1111, 19'h00017);
    step("R5");
    chk("R5", "no bwe read", core_we, 0);
    chk("R7", "read drives", bus_drive, 1);
    // R2 and R9 both strobes with write inputs
    set_cmd(1, 1, 1, 1, 4'hF, 19'h00023);
    step("R2");
    chk("R9", "cpu start read", core_we, 0);
    chk("R2", "cpu start req", core_req, 1);
    // R3 idle edges hold address
    set_cmd(0, 0, 1, 1, 4'hF, 19'h7FFFF);
    step("R3");
    chk("R3", "held addr", core_addr, 19'h00023);
    // R8 deselect by strobe with chip unselected
    set_sel(0);
    set_cmd(0, 1, 0, 0, '0, 19'h00031);
    step("R8");
    chk("R8", "bus off after deselect", bus_drive, 0);
    chk("R8", "no request", core_req, 0);
    // R1 chip selects each individually wrong: no start
    set_sel(1); sel1 = 1'b0;
    set_cmd(0, 1, 1, 0, '0, 19'h00042);
    step("R1");
    chk("R1", "sel1 low no write", core_we, 0);
    set_sel(1);
    set_cmd(0, 1, 1, 0, '0, 19'h00042);
    step("R1");
    chk("R1", "selected write", core_we, 4'hF);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      bit on = ($urandom % 10) != 0;
      set_sel(on);
      if (($urandom % 8) == 0) begin
        sel0_n = $urandom; sel1 = $urandom; sel2_n = $urandom;
      end
      cpu_as_n = ($urandom % 4) != 0;
      ctl_as_n = ($urandom % 3) == 0;
      all_wr_n = ($urandom % 4) != 0;
      bytes_wr_n = ($urandom % 3) == 0;
      lane_wr_n = $urandom;
      addr_in = $urandom;
      oe_n = $urandom;
      step("R1");
    end
    set_cmd(0, 0, 0, 0, '0, '0);
    step("R3");

    // R5 byte lanes landed in the array as expected
    for (int i = 0; i < 16; i++)
      chk("R5", "memory word", dut_mem[i], exp_mem[i]);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule